// File: doc/BRIEF.md
# Windowed Spike Count Accumulator

This block sits between a spiking network and a conventional neural-network accelerator. It receives one binary spike line per output neuron and, for each line, counts how many clock cycles carried a spike during a fixed window of `WIN` cycles. When a window closes, every lane's count is captured onto one wide output bus and a one-cycle strobe marks the fresh snapshot. All lane counters then start the next window.

One shared phase counter measures the window. Its terminal value both triggers the snapshot and clears every lane counter. Each lane counter is `K = log2(WIN)+1` bits wide. That is just enough to hold a full window of spikes, so no saturation logic is needed. The spike input is sampled on every rising clock edge. The consumer reads the bus whenever the strobe is high, and the bus holds its value until the next strobe.

Top module: `spike_window_acc`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it goes low, `counts_out` is all zeros and `out_valid` is low.
- R2: Lane i's count sits at bits `[i*K +: K]` of `counts_out`, with `K = log2(WIN)+1`. It equals the number of window cycles in which `spike_in[i]` was 1, counted as an unsigned binary number.
- R3: `out_valid` is high for exactly one cycle per window. It first rises after the `WIN`-th rising edge following the release of reset, and then every `WIN` edges after that.
- R4: A lane that spikes in every cycle of a window reports exactly `WIN`, with no wrap to zero.
- R5: A spike in the closing cycle of a window is counted in that window's snapshot. A spike in the cycle right after the window closes is counted in the next window only. No spike is lost and none is counted twice.
- R6: `counts_out` changes only on the edge that raises `out_valid`. It holds its value for the rest of the window.
- R7: Each lane counts only its own spike line. A spike on one lane has no effect on any other lane.
- R8: Asserting reset in the middle of a window drops the partial counts and restarts the window phase. The first snapshot after the release reflects only spikes seen after the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of all counters and outputs |
| spike_in | input | N | One spike bit per lane, sampled every cycle |
| counts_out | output | N*K | Snapshot of all lane counts, lane i at bits [i*K +: K] |
| out_valid | output | 1 | One-cycle strobe marking a new snapshot |

## Verification
The bench builds the block with 16 lanes and a window of 8 cycles. This gives 4-bit lanes whose top bit is set only by a full window of spikes, so a wrap to zero or a dropped closing-cycle spike shows up in the bus value. Using 16 lanes lets per-lane patterns produce every count from 1 to 8 in a single window, and lanes sharing a count check both isolation and the bit field positions. Back-to-back windows with spikes placed only at the first or last cycle examine the seam between windows. A reset applied partway through a window examines the phase restart.

// File: rtl/spike_window_acc.sv
module spike_window_acc #(
  parameter int N   = 128,
  parameter int WIN = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [N-1:0]                    spike_in,
  output logic [N*($clog2(WIN)+1)-1:0]    counts_out,
  output logic                            out_valid
);

  localparam int K = $clog2(WIN) + 1;
  localparam logic [K-1:0] LAST = K'(WIN - 1);

  logic [K-1:0] phase;
  logic         win_end;

  assign win_end = (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= '0;
      out_valid <= 1'b0;
    end else begin
      phase     <= win_end ? '0 : phase + 1'b1;
      out_valid <= win_end;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic [K-1:0] cnt;
    logic [K-1:0] cnt_nxt;

    assign cnt_nxt = cnt + K'(spike_in[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt                 <= '0;
        counts_out[i*K +: K] <= '0;
      end else begin
        cnt <= win_end ? '0 : cnt_nxt;
        if (win_end) counts_out[i*K +: K] <= cnt_nxt;
      end
    end
  end

endmodule

// File: rtl/spike_window_acc_chk.sv
module spike_window_acc_chk #(
  parameter int N   = 128,
  parameter int WIN = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [N-1:0]                 spike_in,
  input logic [N*($clog2(WIN)+1)-1:0] counts_out,
  input logic                         out_valid
);

  localparam int K = $clog2(WIN) + 1;

  initial begin
    assert_win_pow2_R2 : assert (WIN >= 2 && (WIN & (WIN - 1)) == 0)
      else $error("WIN must be a power of two of at least 2");
  end

  logic [K-1:0] tick;
  logic         over;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick <= '0;
    else        tick <= (tick == K'(WIN - 1)) ? '0 : tick + 1'b1;
  end

  always_comb begin
    over = 1'b0;
    for (int i = 0; i < N; i++)
      if (counts_out[i*K +: K] > K'(WIN)) over = 1'b1;
  end

  assert_rst_clear_R1 : assert property (@(posedge clk)
    !rst_n |=> (!out_valid && counts_out == '0));

  assert_single_pulse_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_period_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (tick == K'(WIN - 1)) |=> out_valid);

  assert_hold_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(counts_out));

  assert_no_overflow_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !over);

  wire unused_ok = ^spike_in;

endmodule

bind spike_window_acc spike_window_acc_chk #(.N(N), .WIN(WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .spike_in(spike_in),
  .counts_out(counts_out), .out_valid(out_valid)
);

// File: tb/spike_window_acc_bench.sv
`timescale 1ns/1ps
module spike_window_acc_bench;
  localparam int N   = 16;
  localparam int WIN = 8;
  localparam int K   = $clog2(WIN) + 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   spike_in = '0;
  logic [N*K-1:0] counts_out;
  logic           out_valid;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spike_window_acc #(.N(N), .WIN(WIN)) u_spike_window_acc (
    .clk(clk), .rst_n(rst_n), .spike_in(spike_in),
    .counts_out(counts_out), .out_valid(out_valid)
  );

  function automatic logic [N-1:0] pat(int mode, int j);
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++) begin
      case (mode)
        1: v[i] = 1'b1;
        2: v[i] = (j <= (i % WIN));
        3: v[i] = ((i + j) % 2 == 0);
        4: v[i] = (j == WIN - 1);
        5: v[i] = (j == 0);
        6: v[i] = ((j % ((i % 4) + 1)) == 0);
        7: v[i] = (i == 5);
        default: v[i] = 1'b0;
      endcase
    end
    return v;
  endfunction

  task automatic check(bit ok, string req, string what, logic [N*K-1:0] act, logic [N*K-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Runs one whole window from an aligned negedge; checks R3/R6 inside, R2 etc. at the end.
  task automatic run_window(int mode, string req);
    logic [N*K-1:0] exp = '0;
    logic [N*K-1:0] held;
    bit ok_mid = 1;
    held = counts_out;
    for (int j = 0; j < WIN; j++) begin
      spike_in = pat(mode, j);
      for (int i = 0; i < N; i++) exp[i*K +: K] = exp[i*K +: K] + K'(spike_in[i]);
      if (j > 0 && (out_valid !== 1'b0 || counts_out !== held)) ok_mid = 0;
      @(negedge clk);
    end
    check(ok_mid, "R6", "snapshot held, strobe low mid-window", counts_out, held);
    check(out_valid === 1'b1, "R3", "strobe at window close", {{(N*K-1){1'b0}}, out_valid}, 1);
    check(counts_out === exp, req, $sformatf("lane counts mode %0d", mode), counts_out, exp);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check(counts_out === '0 && out_valid === 1'b0, "R1", "reset state", counts_out, '0);
    rst_n = 1'b1;
  endtask

  task automatic test_seam();
    logic [N*K-1:0] one;
    for (int i = 0; i < N; i++) one[i*K +: K] = K'(1);
    run_window(4, "R5");
    check(counts_out === one, "R5", "closing-cycle spike counted once", counts_out, one);
    run_window(5, "R5");
    check(counts_out === one, "R5", "opening-cycle spike counted once", counts_out, one);
  endtask

  task automatic test_full();
    logic [N*K-1:0] full;
    for (int i = 0; i < N; i++) full[i*K +: K] = K'(WIN);
    run_window(1, "R4");
    check(counts_out === full, "R4", "full window no wrap", counts_out, full);
  endtask

  task automatic test_isolation();
    logic [N*K-1:0] exp = '0;
    exp[5*K +: K] = K'(WIN);
    run_window(7, "R7");
    check(counts_out === exp, "R7", "single active lane", counts_out, exp);
  endtask

  task automatic test_mid_reset();
    logic [N*K-1:0] zero = '0;
    spike_in = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(counts_out === zero && out_valid === 1'b0, "R8", "reset mid-window clears", counts_out, zero);
    @(negedge clk);
    rst_n = 1'b1;
    run_window(2, "R8");
  endtask

  initial begin
    test_reset();
    run_window(0, "R2");
    run_window(2, "R2");
    run_window(3, "R2");
    run_window(6, "R2");
    test_full();
    test_seam();
    test_isolation();
    test_mid_reset();
    run_window(3, "R7");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule